// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Register Port

This block is a slave port through which an 8-bit microcontroller can reach a small bank of registers in programmable logic over its external bus. On that bus the low address byte and the data byte share one lane over time, while the high address byte has its own lane. The port records the address when the address strobe falls. It then answers a read strobe by returning the addressed register on the shared lane. On a write strobe it stores the lane byte into the addressed register.

The shared lane appears as three signals: the byte the host drives, the byte the port drives, and an enable for the port's drive. The strobes come from outside the clock domain. Each one passes through a two-stage synchronizer before the port uses it, and the lane bytes are delayed by the same two stages so that data and strobes stay aligned. A low program-fetch strobe marks a cycle that belongs to program memory, so the port ignores reads and writes while it is low. Every register value is also available on a parallel output for neighbouring logic.

Top module: `mbus_slave`

## Requirements
- R1: A synchronous active-high reset sets all registers and the latched address to zero. While reset is held and after its release, `ad_oe` is 0 and `ad_out` is 0.
- R2: When `ale` falls, the port captures the 16-bit address {`hi_addr`, `ad_in`}. The address then stays unchanged until the next fall of `ale`, whatever the lane does and however many read strobes follow.
- R3: When `wr_n` rises and the latched address hits the window, the lane byte is stored into register (address − base). No other register changes.
- R4: While `rd_n` is low, the latched address hits the window and `psen_n` is high, `ad_oe` is 1 and `ad_out` equals the addressed register.
- R5: Once `rd_n` has been high for two consecutive clock edges, `ad_oe` is 0.
- R6: The window is base 0x8000 through 0x8007 (eight registers, index = address − 0x8000). An access outside it never raises `ad_oe` and never changes a register. This holds even when the low byte matches an in-window address.
- R7: While `psen_n` is low, `ad_oe` stays 0 and a rising `wr_n` changes no register.
- R8: `ad_out` is 0 whenever `ad_oe` is 0. `regs_out[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; its falling edge captures the address |
| psen_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| hi_addr | input | 8 | High address byte lane |
| ad_in | input | 8 | Shared lane as driven by the host |
| ad_out | output | 8 | Shared lane as driven by the port |
| ad_oe | output | 1 | Enable for the port's drive of the shared lane |
| regs_out | output | 64 | All registers, register i in bits 8*i+7 down to 8*i |

## Verification
The bench builds the port with its defaults: base 0x8000 and eight registers. This puts both window edges within a few bus cycles. The bench touches 0x7FFF and 0x8008 on either side of the window. It also touches 0x0003 and 0xC005, whose low bytes alias in-window registers, so a decode that ignores the high byte fails. With only eight registers, the bench can compare every register after each write cycle, so a stray write to a neighbouring register is caught.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    // strobe bundle as seen on the pins
    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    // single-cycle events derived from the synchronized strobes
    typedef struct packed {
        logic addr_take;
        logic write_done;
    } bus_event_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned       count);
        logic [ADDR_W-1:0] off;
        off = addr - base;
        return 32'(off) < count;
    endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage0;
    logic [W-1:0] stage1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage0[b] <= RST_VAL[b];
                stage1[b] <= RST_VAL[b];
            end else begin
                stage0[b] <= d[b];
                stage1[b] <= stage0[b];
            end
        end
    end

    assign q = stage1;
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (take)
            addr_q <= addr_in;
    end

    // R2: address is held between capture events
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(take)) |-> $stable(addr_q));
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_en && (32'(idx) == i))
                regs_q[i] <= wr_data;
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];

        // R3: a register changes only after a write aimed at it
        a_r3_only_target: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (regs_q[i] != $past(regs_q[i])))
            |-> ($past(wr_en) && (32'($past(idx)) == i)));
    end

    assign rd_data = regs_q[idx];
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h8000,
    parameter int          NUM_REGS  = 8,
    localparam int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int         FLAT_W    = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              psen_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [7:0]        hi_addr,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    output logic [FLAT_W-1:0] regs_out
);
    strobe_t           pins;
    strobe_t           cur;
    logic [ADDR_W-1:0] lane_d;
    logic              ale_prev;
    logic              wr_prev;
    bus_event_t        ev;
    logic [ADDR_W-1:0] addr_q;
    logic              hit;
    logic              fetch;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] offset;
    logic [BYTE_W-1:0] rd_data;

    assign pins = '{ale: ale, psen_n: psen_n, rd_n: rd_n, wr_n: wr_n};

    mbus_sync #(.W($bits(strobe_t)), .RST_VAL(STROBE_IDLE)) u_strobe_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins),
        .q   (cur)
    );

    // lane bytes delayed by the same depth so they line up with the strobes
    mbus_sync #(.W(ADDR_W), .RST_VAL('0)) u_lane_delay (
        .clk (clk),
        .rst (rst),
        .d   ({hi_addr, ad_in}),
        .q   (lane_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_prev <= STROBE_IDLE.ale;
            wr_prev  <= STROBE_IDLE.wr_n;
        end else begin
            ale_prev <= cur.ale;
            wr_prev  <= cur.wr_n;
        end
    end

    assign ev.addr_take  = ale_prev & ~cur.ale;
    assign ev.write_done = ~wr_prev & cur.wr_n;

    mbus_addr_latch u_addr (
        .clk     (clk),
        .rst     (rst),
        .take    (ev.addr_take),
        .addr_in (lane_d),
        .addr_q  (addr_q)
    );

    assign hit    = in_window(addr_q, BASE_ADDR, NUM_REGS);
    assign offset = addr_q - BASE_ADDR;
    assign idx    = offset[IDX_W-1:0];
    assign fetch  = ~cur.psen_n;
    assign wr_en  = ev.write_done & hit & ~fetch;
    assign ad_oe  = ~cur.rd_n & hit & ~fetch;
    assign ad_out = ad_oe ? rd_data : '0;

    mbus_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .idx       (idx),
        .wr_data   (lane_d[BYTE_W-1:0]),
        .rd_data   (rd_data),
        .regs_flat (regs_out)
    );

    // R5: read strobe high at the pins for two edges releases the lane
    a_r5_oe_release: assert property (@(posedge clk) disable iff (rst)
        $past(rd_n, 2) |-> !ad_oe);

    // R7: a program fetch never gets the lane driven
    a_r7_fetch_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(psen_n, 2) |-> !ad_oe);

    // R8: the parallel view tracks what the lane returns during a read
    a_r8_view_match: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (ad_out == regs_out[32'(idx)*BYTE_W +: BYTE_W]));
endmodule

// File: tb/tb_mbus_slave.sv
module tb_mbus_slave;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ale = 1'b0;
    logic         psen_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [7:0]   hi_addr = 8'h00;
    logic [7:0]   ad_in = 8'hFF;
    logic [7:0]   ad_out;
    logic         ad_oe;
    logic [N*8-1:0] regs_out;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [N];

    always #4 clk = ~clk;

    mbus_slave dut (
        .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .hi_addr(hi_addr), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .regs_out(regs_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic hits(input logic [15:0] a);
        return (a >= 16'h8000) && (a <= 16'h8007);
    endfunction

    task automatic check_all_regs(input string tag);
        for (int i = 0; i < N; i++)
            check(tag, 32'(regs_out[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic addr_phase(input logic [15:0] a);
        @(negedge clk);
        hi_addr = a[15:8];
        ad_in   = a[7:0];
        ale     = 1'b1;
        wait_n(4);
        ale = 1'b0;
        wait_n(4);
    endtask

    // write cycle; psen_low makes it look like a fetch cycle
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic psen_low, input string tag);
        addr_phase(a);
        ad_in  = d;
        psen_n = ~psen_low;
        wr_n   = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(5);
        psen_n = 1'b1;
        ad_in  = 8'hFF;
        if (hits(a) && !psen_low) model[a[2:0]] = d;
        wait_n(1);
        check_all_regs(tag);
    endtask

    task automatic read_strobe(input logic psen_low, input logic exp_oe,
                               input logic [7:0] exp_d, input string tag);
        ad_in  = 8'h5A;
        psen_n = ~psen_low;
        rd_n   = 1'b0;
        wait_n(4);
        check({tag, " oe"}, 32'(ad_oe), 32'(exp_oe));
        check({tag, " data"}, 32'(ad_out), 32'(exp_oe ? exp_d : 8'h00));
        rd_n = 1'b1;
        wait_n(3);
        check({tag, " R5 release"}, 32'(ad_oe), 32'h0);
        check({tag, " R8 quiet lane"}, 32'(ad_out), 32'h0);
        psen_n = 1'b1;
        ad_in  = 8'hFF;
        wait_n(2);
    endtask

    task automatic bus_read(input logic [15:0] a, input logic psen_low, input string tag);
        addr_phase(a);
        read_strobe(psen_low, hits(a) && !psen_low, hits(a) ? model[a[2:0]] : 8'h00, tag);
    endtask

    task automatic t_reset;
        check("R1 oe after reset", 32'(ad_oe), 32'h0);
        check("R1 lane after reset", 32'(ad_out), 32'h0);
        check_all_regs("R1 regs after reset");
    endtask

    task automatic t_write_all;
        for (int i = 0; i < N; i++)
            bus_write(16'h8000 + 16'(i), 8'(8'h11 * (i + 1) ^ 8'hA0), 1'b0, "R3 write each");
    endtask

    task automatic t_read_all;
        for (int i = 0; i < N; i++)
            bus_read(16'h8000 + 16'(i), 1'b0, "R4 read each");
    endtask

    task automatic t_window_edges;
        bus_write(16'h7FFF, 8'hC3, 1'b0, "R6 below window");
        bus_write(16'h8008, 8'hC4, 1'b0, "R6 above window");
        bus_write(16'h0003, 8'hC5, 1'b0, "R6 alias low byte");
        bus_write(16'hC005, 8'hC6, 1'b0, "R6 alias high bits");
        bus_read(16'h7FFF, 1'b0, "R6 read below");
        bus_read(16'h8008, 1'b0, "R6 read above");
        bus_read(16'h0003, 1'b0, "R6 read alias");
        bus_write(16'h8007, 8'h3C, 1'b0, "R6 last in window");
        bus_read(16'h8007, 1'b0, "R6 read last");
    endtask

    task automatic t_fetch;
        bus_write(16'h8001, 8'hEE, 1'b1, "R7 write during fetch");
        bus_read(16'h8001, 1'b1, "R7 read during fetch");
    endtask

    task automatic t_latch_hold;
        bus_write(16'h8002, 8'h77, 1'b0, "R2 setup");
        addr_phase(16'h8002);
        read_strobe(1'b0, 1'b1, 8'h77, "R2 first read");
        read_strobe(1'b0, 1'b1, 8'h77, "R2 second read no ale");
        check("R8 parallel view", 32'(regs_out[2*8 +: 8]), 32'h77);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        wait_n(3);
        check("R1 oe in reset", 32'(ad_oe), 32'h0);
        rst = 1'b0;
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        wait_n(2);
        check_all_regs("R1 regs after second reset");
        bus_read(16'h8002, 1'b0, "R1 read zero after reset");
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_write_all();
        t_read_all();
        t_window_edges();
        t_fetch();
        t_latch_hold();
        t_reset_again();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule